// File: doc/BRIEF.md
# Banked Interrupt Event Aggregator

This block collects up to 24 one-cycle event pulses into three 8-bit status banks and drives a single active-high interrupt request toward a host. Every bank has two masks of its own. The capture mask decides whether an incoming pulse is recorded at all. The line mask decides whether a recorded bit may raise the interrupt line. Recorded bits stay set until the host clears them. The host clears them by writing one byte to any status address. That single write empties all three banks together, whatever the data value is.

The host reaches the registers over a byte-wide bus with read and write strobes. An address is taken only when `addr_ld_i` is high. After that, every access advances an internal address pointer by one. This lets the host read or write three neighbouring registers in one burst, for example all three status banks or all three masks. The bus is meant for read-modify-write of the masks. Read data is registered and appears the cycle after the read strobe.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, all status bits are 0, all six mask registers read 0xFF, `irq_o` is 0 and `rdata_o` is 0x00.
- R2: A pulse on `evt_i[n]` whose capture-mask bit is 0 sets status bit n. The bit is visible in the register at address n/8, bit n%8, from the next cycle on.
- R3: A pulse on a source whose capture-mask bit is 1 leaves its status bit at 0.
- R4: A status bit, once set, stays set until a clearing write, even after its event input returns low.
- R5: A write of any data value to address 0, 1 or 2 clears all 24 status bits in the same clock edge.
- R6: An event pulse in the same cycle as a clearing write is not lost: its status bit reads 1 after the clear.
- R7: `irq_o` is high exactly one cycle after some status bit is set while its line-mask bit is 0, and low one cycle after no such bit remains.
- R8: Sources 12 and 23 are reserved. Their status bits never set and always read 0.
- R9: A cycle with `addr_ld_i` high uses `addr_i` as the access address. Each read or write then moves the pointer by one, so later accesses made without a load reach the following addresses.
- R10: Line masks (addresses 3 to 5) and capture masks (addresses 6 to 8) read back the last value written to them.
- R11: Reads of addresses 9 to 15 return 0x00.
- R12: Read data for a strobe in cycle k appears on `rdata_o` after the clock edge that ends cycle k and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 24 | One-cycle event pulses, one per source |
| addr_ld_i | input | 1 | Load `addr_i` as the access address this cycle |
| addr_i | input | 4 | Start address of an access or burst |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The bench sends a pulse in the same cycle as a clearing write. A design that let the clear win would lose that event. It also clears through the C status address with a nonzero data byte, to catch a design that clears only one bank or uses the data as a bit mask. The reserved sources are pulsed with capture enabled, and reads then confirm that bits 12 and 23 stay zero. Reads made without a load after a burst catch a pointer that fails to advance or restarts. The cycle in which the interrupt goes high and low is checked, to catch an output that is not registered or is registered twice.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int EVT_W     = BANK_W * NUM_BANKS;
    localparam int ADDR_W    = 4;
    localparam int SEL_W     = $clog2(NUM_BANKS);

    // sources that never record: 12 and 23
    localparam logic [EVT_W-1:0] RSV_BITS = (EVT_W'(1) << 12) | (EVT_W'(1) << 23);

    localparam logic [ADDR_W-1:0] LINE_BASE = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] SMSK_BASE = ADDR_W'(2 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] MAP_END   = ADDR_W'(3 * NUM_BANKS);

    typedef enum logic [1:0] {
        KIND_STAT,
        KIND_LINE,
        KIND_SMSK,
        KIND_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [SEL_W-1:0] bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t         s;
        logic [ADDR_W-1:0] off;
        s.kind = KIND_NONE;
        off    = '0;
        if (a < LINE_BASE) begin
            s.kind = KIND_STAT;
            off    = a;
        end else if (a < SMSK_BASE) begin
            s.kind = KIND_LINE;
            off    = a - LINE_BASE;
        end else if (a < MAP_END) begin
            s.kind = KIND_SMSK;
            off    = a - SMSK_BASE;
        end
        s.bank = off[SEL_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/irqagg_addr_ptr.sv
module irqagg_addr_ptr
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              access,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_q;

    assign cur_addr = ld ? ld_addr : ptr_q;
    assign ptr      = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (access) begin
            ptr_q <= cur_addr + ADDR_W'(1);
        end else if (ld) begin
            ptr_q <= ld_addr;
        end
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int              W   = 8,
    parameter logic [W-1:0]    RSV = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_all,
    input  logic         wr_line,
    input  logic         wr_smsk,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] line_mask,
    output logic [W-1:0] smsk,
    output logic         pend
);
    logic [W-1:0] status_q, line_q, smsk_q, capture;

    assign capture = evt & ~smsk_q & ~RSV;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            line_q   <= '1;
            smsk_q   <= '1;
        end else begin
            if (clr_all) status_q <= capture;
            else         status_q <= status_q | capture;
            if (wr_line) line_q <= wdata;
            if (wr_smsk) smsk_q <= wdata;
        end
    end

    assign status    = status_q;
    assign line_mask = line_q;
    assign smsk      = smsk_q;
    assign pend      = |(status_q & ~line_q);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              addr_ld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [BANK_W-1:0] wdata_i,
    input  logic              re_i,
    output logic [BANK_W-1:0] rdata_o,
    output logic              irq_o
);
    logic [ADDR_W-1:0] cur_addr, ptr_cur;
    reg_sel_t          sel;
    logic              access, clr_all;
    logic [EVT_W-1:0]  status_vec, lmask_vec, smask_vec;
    logic [NUM_BANKS-1:0] pend_bank;
    logic [BANK_W-1:0] rd_byte, rdata_q;
    logic              irq_q;

    assign access = we_i | re_i;

    irqagg_addr_ptr ptr_i (
        .clk(clk), .rst(rst), .ld(addr_ld_i), .ld_addr(addr_i),
        .access(access), .cur_addr(cur_addr), .ptr(ptr_cur)
    );

    assign sel     = decode_addr(cur_addr);
    assign clr_all = we_i && (sel.kind == KIND_STAT);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (sel.bank == SEL_W'(b));
        irqagg_bank #(.W(BANK_W), .RSV(RSV_BITS[b*BANK_W +: BANK_W])) bank_i (
            .clk(clk), .rst(rst),
            .evt(evt_i[b*BANK_W +: BANK_W]),
            .clr_all(clr_all),
            .wr_line(we_i && hit && sel.kind == KIND_LINE),
            .wr_smsk(we_i && hit && sel.kind == KIND_SMSK),
            .wdata(wdata_i),
            .status(status_vec[b*BANK_W +: BANK_W]),
            .line_mask(lmask_vec[b*BANK_W +: BANK_W]),
            .smsk(smask_vec[b*BANK_W +: BANK_W]),
            .pend(pend_bank[b])
        );
    end

    always_comb begin
        unique case (sel.kind)
            KIND_STAT: rd_byte = status_vec[sel.bank*BANK_W +: BANK_W];
            KIND_LINE: rd_byte = lmask_vec[sel.bank*BANK_W +: BANK_W];
            KIND_SMSK: rd_byte = smask_vec[sel.bank*BANK_W +: BANK_W];
            default:   rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (re_i) rdata_q <= rd_byte;
            irq_q <= |pend_bank;
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EVT_W-1:0]  evt,
    input logic [EVT_W-1:0]  st,
    input logic [EVT_W-1:0]  smask,
    input logic [EVT_W-1:0]  lmask,
    input logic              clr,
    input logic              access,
    input logic              ld,
    input logic [ADDR_W-1:0] ptr,
    input logic              irq
);
    // R3
    no_masked_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ((st & ~$past(st)) & ~($past(evt) & ~$past(smask))) == '0);

    // R4
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(clr) |-> ((st & $past(st)) == $past(st)));

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((st & ~$past(evt)) == '0));

    // R7
    irq_timing_chk: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|(st & ~lmask)));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st[12] == 1'b0) && (st[23] == 1'b0));

    // R9
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !ld) |=> ptr == $past(ptr) + ADDR_W'(1));
endmodule

bind irq_status_agg irqagg_chk chk_i (
    .clk(clk), .rst(rst), .evt(evt_i), .st(status_vec), .smask(smask_vec),
    .lmask(lmask_vec), .clr(clr_all), .access(access), .ld(addr_ld_i),
    .ptr(ptr_cur), .irq(irq_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] evt_i = '0;
    logic        addr_ld_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        we_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic        re_i = 1'b0;
    logic [7:0]  rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_issued = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .addr_ld_i(addr_ld_i), .addr_i(addr_i),
        .we_i(we_i), .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // monitor: compare registered read data the half cycle after its edge
    always @(posedge clk) rd_issued <= re_i;
    always @(negedge clk) begin
        if (rd_issued && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata_o !== e) begin
                n_bad++;
                $display("FAIL %s: rdata got %02h expected %02h", t, rdata_o, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_irq(input logic e, input string t);
        n_chk++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq_o, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic ld, input logic [7:0] d);
        addr_ld_i = ld; addr_i = a; we_i = 1'b1; wdata_i = d;
        tick();
        addr_ld_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic ld, input logic [7:0] e, input string t);
        addr_ld_i = ld; addr_i = a; re_i = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        tick();
        addr_ld_i = 1'b0; re_i = 1'b0;
    endtask

    task automatic pulse(input logic [23:0] v);
        evt_i = v;
        tick();
        evt_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check_irq(1'b0, "R1");
        n_chk++;
        if (rdata_o !== 8'h00) begin n_bad++; $display("FAIL R1: rdata got %02h expected 00", rdata_o); end
        rd(4'd3, 1, 8'hFF, "R1 line A");
        rd(4'd0, 1, 8'h00, "R1 status A");
        rd(4'd8, 1, 8'hFF, "R1 smask C");

        // R9 burst write of capture masks, R10 readback
        wr(4'd6, 1, 8'h00); wr(4'd0, 0, 8'h00); wr(4'd0, 0, 8'h00);
        rd(4'd6, 1, 8'h00, "R10 smask A");
        rd(4'd0, 0, 8'h00, "R9 R10 smask B");

        // R2 capture: sources 0 and 9
        pulse(24'h000201);
        rd(4'd0, 1, 8'h01, "R2 status A");
        rd(4'd0, 0, 8'h02, "R2 R9 status B");
        rd(4'd0, 0, 8'h00, "R2 R9 status C");
        rd(4'd0, 0, 8'hFF, "R9 pointer to line A");
        check_irq(1'b0, "R7 line masked");

        // R7 unmask source 0 on the line
        wr(4'd3, 1, 8'hFE);
        check_irq(1'b0, "R7 one cycle later");
        tick();
        check_irq(1'b1, "R7 asserted");
        rd(4'd3, 1, 8'hFE, "R10 line A");

        // R4 sticky
        repeat (5) tick();
        rd(4'd0, 1, 8'h01, "R4 sticky");

        // R8 reserved sources
        pulse(24'h801000);
        rd(4'd1, 1, 8'h02, "R8 bit12");
        rd(4'd2, 1, 8'h00, "R8 bit23");

        // R3 capture mask blocks source 16
        wr(4'd8, 1, 8'hFF);
        pulse(24'h010000);
        rd(4'd2, 1, 8'h00, "R3 masked source");

        // R5 clear through C with nonzero data
        wr(4'd2, 1, 8'h5A);
        check_irq(1'b1, "R7 still high at clear");
        tick();
        check_irq(1'b0, "R7 low after clear");
        rd(4'd0, 1, 8'h00, "R5 A");
        rd(4'd0, 0, 8'h00, "R5 B");
        rd(4'd0, 0, 8'h00, "R5 C");

        // R6 event during clear
        pulse(24'h000200);
        evt_i = 24'h000002;
        wr(4'd1, 1, 8'h00);
        evt_i = '0;
        rd(4'd0, 1, 8'h02, "R6 survives");
        rd(4'd1, 1, 8'h00, "R6 others cleared");

        // R11 unmapped
        rd(4'd9, 1, 8'h00, "R11 addr9");
        rd(4'd15, 1, 8'h00, "R11 addr15");

        // R9 R10 burst write of line masks
        wr(4'd3, 1, 8'h11); wr(4'd0, 0, 8'h22); wr(4'd0, 0, 8'h33);
        rd(4'd3, 1, 8'h11, "R10 burst line A");
        rd(4'd0, 0, 8'h22, "R10 burst line B");
        rd(4'd0, 0, 8'h33, "R10 burst line C");
        tick();

        // R12 data holds without a read
        n_chk++;
        if (rdata_o !== 8'h33) begin n_bad++; $display("FAIL R12: rdata got %02h expected 33", rdata_o); end
        tick();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule